// File: doc/BRIEF.md
# ECP Reverse-Channel Receive FIFO

This block is the inbound data path of a parallel-port host running in extended-capability mode. When the port mode selects extended-capability operation and the direction control selects reverse, the block runs the peripheral-to-host byte handshake on its own. Each time the peripheral presents a byte, the block answers with its host-acknowledge line. When the peripheral withdraws its strobe, the block latches the eight data lines and the BUSY line together into a 9-bit FIFO entry. The BUSY level marks the byte as a command or as data. The processor never takes part in a transfer. It only drains the FIFO.

The processor sees two registers through a small read/write port. A read of the data register returns the oldest byte and removes it. The status register reports the empty flag, the full flag and the command tag of the oldest entry. In the plain FIFO mode, and in extended-capability mode with the forward direction, the processor can load the FIFO itself through the data register. In every other mode, writes to the data register are discarded. The block stops answering the peripheral while the FIFO is full, so no byte is ever lost. While the port clock is frozen the block reports the FIFO as empty.

Top module: `ecp_rev_fifo`

## Requirements
- R1: After reset the status register reads 8'h01: bit 0 (empty) = 1, bit 1 (full) = 0, bit 2 (head tag) = 0. `host_ack` is low.
- R2: With `port_mode` = 3'b011 and `dir_rev` = 1, `host_ack` goes high within 10 cycles of `periph_strobe` going high. Once `periph_strobe` falls, `host_ack` returns low within 10 cycles and one entry {`periph_busy`, `periph_data`} is appended to the FIFO.
- R3: For every other combination of `port_mode` (000, 001, 010, 011 with `dir_rev` = 0, 100 to 111), a high `periph_strobe` leaves `host_ack` low and the FIFO untouched.
- R4: Status bit 2 shows the BUSY level captured with the oldest entry. It reads 0 whenever the FIFO is empty.
- R5: The FIFO holds 16 entries. Status bit 1 is 1 when 16 entries are held. While the FIFO is full, a high strobe gets no `host_ack`. The held handshake completes after one entry is popped.
- R6: With `cpu_sel` = 0, `cpu_rdata` shows the oldest byte. A `cpu_rd` pulse removes exactly that byte, and bytes come out in arrival order.
- R7: A write to the status register (`cpu_sel` = 1) changes nothing. A status read removes nothing.
- R8: A data-register write pushes `cpu_wdata` with tag 0 only when `port_mode` = 010, or when `port_mode` = 011 and `dir_rev` = 0. In every other mode the write is discarded.
- R9: While `clk_frozen` = 1, status bit 0 reads 1 and a data read removes nothing. The stored entries are visible again once `clk_frozen` returns to 0.
- R10: A data read of an empty FIFO has no effect, and later transfers still arrive in order.
- R11: `host_ack` stays high for as long as the synchronised strobe stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| port_mode | input | 3 | Port operating mode (011 extended capability, 010 plain FIFO, 000/001 software-driven) |
| dir_rev | input | 1 | Direction control: 0 forward, 1 reverse |
| clk_frozen | input | 1 | Port clock frozen; forces the empty indication |
| periph_strobe | input | 1 | Peripheral byte strobe, high = asserted, asynchronous |
| periph_busy | input | 1 | Peripheral BUSY, captured as the command/data tag |
| periph_data | input | 8 | Peripheral data lines |
| host_ack | output | 1 | Host acknowledge toward the peripheral |
| cpu_sel | input | 1 | Register select: 0 data, 1 status |
| cpu_rd | input | 1 | Read strobe, one cycle; pops when the data register is selected |
| cpu_wr | input | 1 | Write strobe, one cycle |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of the selected register |

## Verification
The hardest situation to reach is a peripheral strobe that is held while the FIFO is full, followed by a processor pop in the middle of that stall. The stimulus fills all sixteen entries with real handshakes, then raises the strobe again and holds it. After checking that the acknowledge stays low, it pops one byte. It then confirms that the delayed transfer completes and lands behind the fifteen older bytes. A sweep over every mode and direction code shows that only one combination answers the peripheral.

// File: rtl/ecp_rev_pkg.sv
package ecp_rev_pkg;

    localparam logic [2:0] PM_SW0  = 3'b000;
    localparam logic [2:0] PM_SW1  = 3'b001;
    localparam logic [2:0] PM_FIFO = 3'b010;
    localparam logic [2:0] PM_ECP  = 3'b011;

    localparam logic REG_DATA = 1'b0;
    localparam logic REG_STAT = 1'b1;

    localparam int ST_EMPTY = 0;
    localparam int ST_FULL  = 1;
    localparam int ST_TAG   = 2;

    typedef struct packed {
        logic       tag;     // BUSY level at capture: command/data marker
        logic [7:0] value;
    } entry_t;

    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_HOLD = 1'b1
    } hs_state_t;

    function automatic logic auto_fill(input logic [2:0] mode, input logic rev);
        return (mode == PM_ECP) && rev;
    endfunction

    function automatic logic cpu_fill(input logic [2:0] mode, input logic rev);
        return (mode == PM_FIFO) || ((mode == PM_ECP) && !rev);
    endfunction

endpackage

// File: rtl/ecp_rev_sync.sv
module ecp_rev_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/ecp_rev_buf.sv
module ecp_rev_buf
    import ecp_rev_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  entry_t        wr_entry,
    input  logic          pop,
    output entry_t        rd_entry,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);
    localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CFULL = CW'(DEPTH);

    entry_t          store [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic            do_push, do_pop;

    assign full    = (count == CFULL);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rd_entry = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/ecp_rev_hs.sv
module ecp_rev_hs
    import ecp_rev_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       strobe_s,
    input  logic       space,
    input  logic       busy,
    input  logic [7:0] data,
    output logic       ack,
    output logic       push,
    output entry_t     entry
);
    hs_state_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= HS_IDLE;
            ack   <= 1'b0;
        end else begin
            case (state)
                HS_IDLE: if (enable && strobe_s && space) begin
                    state <= HS_HOLD;
                    ack   <= 1'b1;
                end
                HS_HOLD: if (!strobe_s) begin
                    state <= HS_IDLE;
                    ack   <= 1'b0;
                end
                default: state <= HS_IDLE;
            endcase
        end
    end

    // Peripheral keeps data and BUSY stable until ack falls, so the sample
    // taken on the strobe release is settled.
    assign push        = (state == HS_HOLD) && !strobe_s;
    assign entry.tag   = busy;
    assign entry.value = data;
endmodule

// File: rtl/ecp_rev_fifo.sv
module ecp_rev_fifo
    import ecp_rev_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] port_mode,
    input  logic       dir_rev,
    input  logic       clk_frozen,
    input  logic       periph_strobe,
    input  logic       periph_busy,
    input  logic [7:0] periph_data,
    output logic       host_ack,
    input  logic       cpu_sel,
    input  logic       cpu_rd,
    input  logic       cpu_wr,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata
);
    logic          strobe_s;
    logic          auto_en;
    logic          hs_push, cpu_push, fifo_push, fifo_pop;
    entry_t        hs_entry, cpu_entry, wr_entry, head;
    logic          full, empty;
    logic [CW-1:0] count;

    ecp_rev_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(periph_strobe), .dout(strobe_s)
    );

    assign auto_en = auto_fill(port_mode, dir_rev);

    ecp_rev_hs u_hs (
        .clk(clk), .rst(rst), .enable(auto_en), .strobe_s(strobe_s),
        .space(!full), .busy(periph_busy), .data(periph_data),
        .ack(host_ack), .push(hs_push), .entry(hs_entry)
    );

    assign cpu_push        = cpu_wr && (cpu_sel == REG_DATA) && cpu_fill(port_mode, dir_rev);
    assign cpu_entry.tag   = 1'b0;
    assign cpu_entry.value = cpu_wdata;

    assign fifo_push = hs_push | cpu_push;
    assign wr_entry  = hs_push ? hs_entry : cpu_entry;
    assign fifo_pop  = cpu_rd && (cpu_sel == REG_DATA) && !clk_frozen;

    ecp_rev_buf #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst(rst), .push(fifo_push), .wr_entry(wr_entry),
        .pop(fifo_pop), .rd_entry(head), .full(full), .empty(empty),
        .count(count)
    );

    always_comb begin
        cpu_rdata = '0;
        if (cpu_sel == REG_DATA) begin
            cpu_rdata = head.value;
        end else begin
            cpu_rdata[ST_EMPTY] = empty | clk_frozen;
            cpu_rdata[ST_FULL]  = full;
            cpu_rdata[ST_TAG]   = head.tag & !empty;
        end
    end
endmodule

// File: rtl/ecp_rev_chk.sv
module ecp_rev_chk #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          host_ack,
    input logic          strobe_s,
    input logic          hs_push,
    input logic          fifo_pop,
    input logic          full,
    input logic          empty,
    input logic [CW-1:0] count
);
    assert_ack_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(host_ack) |-> ($past(strobe_s) && !$past(full)));

    assert_store_on_release_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(host_ack) |-> $past(hs_push));

    assert_ack_held_R11: assert property (@(posedge clk) disable iff (rst)
        (host_ack && strobe_s) |=> host_ack);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (full && !fifo_pop) |=> (full && $stable(count)));

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (rst)
        (empty && !hs_push && !$rose(count)) |=> (count <= 1));
endmodule

bind ecp_rev_fifo ecp_rev_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .host_ack(host_ack), .strobe_s(strobe_s),
    .hs_push(hs_push), .fifo_pop(fifo_pop), .full(full), .empty(empty),
    .count(count)
);

// File: tb/ecp_rev_fifo_test.sv
module ecp_rev_fifo_test;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] port_mode = 3'b000;
    logic       dir_rev = 1'b0;
    logic       clk_frozen = 1'b0;
    logic       periph_strobe = 1'b0;
    logic       periph_busy = 1'b0;
    logic [7:0] periph_data = 8'h00;
    logic       host_ack;
    logic       cpu_sel = 1'b0;
    logic       cpu_rd = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    ecp_rev_fifo uut (
        .clk(clk), .rst(rst), .port_mode(port_mode), .dir_rev(dir_rev),
        .clk_frozen(clk_frozen), .periph_strobe(periph_strobe),
        .periph_busy(periph_busy), .periph_data(periph_data),
        .host_ack(host_ack), .cpu_sel(cpu_sel), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    function automatic logic ptag(input int i);
        return (i % 3) == 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_status(output logic [7:0] v);
        cpu_sel = 1'b1;
        #1 v = cpu_rdata;
    endtask

    task automatic pop_byte(output logic [7:0] v);
        cpu_sel = 1'b0;
        #1 v = cpu_rdata;
        cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic cpu_write(input logic sel, input logic [7:0] d);
        cpu_sel = sel; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    // peripheral side of one reverse byte; ok=1 when both edges of host_ack seen
    task automatic periph_xfer(input logic [7:0] d, input logic b, output bit ok);
        int w;
        ok = 1'b0;
        periph_data = d; periph_busy = b; periph_strobe = 1'b1;
        w = 0;
        while (!host_ack && w < 10) begin @(negedge clk); w++; end
        if (!host_ack) begin periph_strobe = 1'b0; cyc(3); return; end
        cyc(3);
        check(host_ack == 1'b1, "R11 ack held while strobe high", host_ack, 1);
        periph_strobe = 1'b0;
        w = 0;
        while (host_ack && w < 10) begin @(negedge clk); w++; end
        ok = !host_ack;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] st, v;
        bit ok;
        int seen;
        int w;

        cyc(3);
        rst = 1'b0;
        cyc(1);

        // R1 reset state
        read_status(st);
        check(st == 8'h01, "R1 status after reset", st, 8'h01);
        check(host_ack == 1'b0, "R1 ack after reset", host_ack, 0);

        // R3 sweep of every mode/direction that must not answer
        for (int m = 0; m < 8; m++) begin
            for (int d = 0; d < 2; d++) begin
                if (m == 3 && d == 1) continue;
                port_mode = 3'(m); dir_rev = 1'(d);
                periph_data = 8'h5a; periph_strobe = 1'b1;
                seen = 0;
                for (int k = 0; k < 12; k++) begin
                    @(negedge clk);
                    if (host_ack) seen++;
                end
                periph_strobe = 1'b0;
                cyc(4);
                check(seen == 0, "R3 no ack outside reverse ECP", seen, 0);
                read_status(st);
                check(st == 8'h01, "R3 FIFO untouched", st, 8'h01);
            end
        end

        // R2/R4 fill all entries by handshake
        port_mode = 3'b011; dir_rev = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            periph_xfer(pat(i), ptag(i), ok);
            check(ok, "R2 handshake completes", ok, 1);
        end
        read_status(st);
        check(st[1] == 1'b1, "R5 full after 16", st[1], 1);
        check(st[2] == ptag(0), "R4 head tag", st[2], ptag(0));

        // R5 stalled while full
        periph_data = pat(DEPTH); periph_busy = ptag(DEPTH); periph_strobe = 1'b1;
        seen = 0;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            if (host_ack) seen++;
        end
        check(seen == 0, "R5 no ack while full", seen, 0);

        // R6 pop head; the stalled transfer then completes
        pop_byte(v);
        check(v == pat(0), "R6 first byte", v, pat(0));
        w = 0;
        while (!host_ack && w < 10) begin @(negedge clk); w++; end
        check(host_ack == 1'b1, "R5 resume after pop", host_ack, 1);
        periph_strobe = 1'b0;
        cyc(6);
        check(host_ack == 1'b0, "R2 ack drops after release", host_ack, 0);

        for (int i = 1; i <= DEPTH; i++) begin
            read_status(st);
            check(st[2] == ptag(i), "R4 tag in order", st[2], ptag(i));
            pop_byte(v);
            check(v == pat(i), "R6 byte order", v, pat(i));
        end
        read_status(st);
        check(st == 8'h01, "R4 empty reads tag 0", st, 8'h01);

        // R10 read of empty FIFO
        pop_byte(v);
        read_status(st);
        check(st == 8'h01, "R10 still empty", st, 8'h01);
        periph_xfer(8'hc3, 1'b1, ok);
        periph_xfer(8'h3c, 1'b0, ok);
        pop_byte(v);
        check(v == 8'hc3, "R10 order kept", v, 8'hc3);
        pop_byte(v);
        check(v == 8'h3c, "R10 order kept 2", v, 8'h3c);

        // R7 status write/read
        cpu_write(1'b1, 8'hff);
        read_status(st);
        check(st == 8'h01, "R7 status write ignored", st, 8'h01);
        periph_xfer(8'h77, 1'b0, ok);
        cyc(1);
        read_status(st); cpu_rd = 1'b1; cyc(1); cpu_rd = 1'b0;
        read_status(st); cpu_rd = 1'b1; cyc(1); cpu_rd = 1'b0;
        read_status(st);
        check(st == 8'h00, "R7 status read no pop", st, 8'h00);

        // R9 frozen clock
        clk_frozen = 1'b1;
        read_status(st);
        check(st[0] == 1'b1, "R9 empty when frozen", st[0], 1);
        pop_byte(v);
        clk_frozen = 1'b0;
        read_status(st);
        check(st[0] == 1'b0, "R9 entry kept", st[0], 0);
        pop_byte(v);
        check(v == 8'h77, "R9 byte intact", v, 8'h77);

        // R8 processor writes
        cpu_write(1'b0, 8'h11);
        read_status(st);
        check(st == 8'h01, "R8 write ignored in reverse ECP", st, 8'h01);
        for (int m = 0; m < 2; m++) begin
            port_mode = 3'(m);
            cpu_write(1'b0, 8'h22);
            read_status(st);
            check(st == 8'h01, "R8 write ignored in software mode", st, 8'h01);
        end
        port_mode = 3'b010;
        for (int i = 0; i < 5; i++) cpu_write(1'b0, pat(i + 40));
        for (int i = 0; i < 5; i++) begin
            read_status(st);
            check(st[2] == 1'b0, "R8 cpu entry tag 0", st[2], 0);
            pop_byte(v);
            check(v == pat(i + 40), "R8 FIFO mode write", v, pat(i + 40));
        end
        port_mode = 3'b011; dir_rev = 1'b0;
        cpu_write(1'b0, 8'h9d);
        pop_byte(v);
        check(v == 8'h9d, "R8 forward ECP write", v, 8'h9d);
        read_status(st);
        check(st == 8'h01, "R8 empty after", st, 8'h01);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule